// File: doc/BRIEF.md
# SPI Serial Byte Memory Target

This block acts as the target side of an SPI link and behaves like a small byte-wide serial memory. The memory is a 512-byte register file. A fast system clock oversamples the four link inputs: serial clock, active-low select, data in and active-low pause. Each select-low frame starts with an 8-bit instruction. The instruction can toggle a write-enable latch, read or write a small status byte, or read or write the array through a 9-bit byte address. The top address bit travels inside the instruction byte.

Reads stream bytes for as long as the serial clock runs. The pointer advances on its own and wraps from the last byte to the first. Writes collect up to one 16-byte page in a buffer, and the column wraps inside that page. The buffered bytes reach the array only when select rises on a whole-byte boundary. The write must also be enabled and must fall outside the region that the two block-protect bits guard. An accepted write starts an internal write-cycle timer, and the status byte reports it as busy. While the timer runs, only the status read is served. The data output comes with a separate drive enable, which the chip wraps in its tri-state pad.

Top module: `spi_mem_target`

## Requirements
- R1: Only modes 0 and 3 are supported. Data in is captured on rising serial-clock edges, and the data output changes only after falling serial-clock edges. Either idle clock level works.
- R2: The output enable is 0 while select is high. Each select-low period is an independent frame, and its state restarts when select returns high.
- R3: Opcode 0x06 sets the write-enable latch (WEL) and opcode 0x04 clears it. Each takes effect once its eighth bit is captured.
- R4: After an opcode other than the six defined ones, the rest of that frame has no effect. Later bytes in the frame are not decoded and the output stays disabled.
- R5: Opcode 0x05 returns the status byte {4'b1111, BP1, BP0, WEL, RDY}, MSB first. Bits 3:2 are the protect field, bit 1 is WEL and bit 0 is busy. The byte is repeated, refreshed each time, while the clock keeps running.
- R6: Opcode 0000_A011 reads the array. Bit 3 of the opcode is address bit 8, and the next byte gives address bits 7..0. Data bytes follow MSB first from consecutive addresses, wrapping from 0x1FF to 0x000.
- R7: Opcode 0000_A010 writes the array, with the address formed as in R6. Data bytes fill one 16-byte page, and the low 4 address bits wrap within the page. Nothing is written unless select rises when a whole number of data bytes has been captured.
- R8: Opcode 0x01 takes one data byte whose bits 3:2 become BP1,BP0. The change lands only when select rises on a byte boundary with WEL set.
- R9: A write that is committed clears WEL and holds RDY at 1 for WC_CYCLES system clocks. A write issued with WEL clear changes neither the array nor the status.
- R10: While RDY is 1, every opcode other than 0x05 is ignored for the rest of its frame.
- R11: Protect field 01 guards addresses with bits 8:7 = 11, field 10 guards addresses with bit 8 = 1, and field 11 guards the whole array. A write to a guarded page is dropped and leaves WEL unchanged.
- R12: Pulling the pause input low while the clock is low freezes the transfer and disables the output, and clock edges during the pause are ignored. Raising the pause input while the clock is low resumes from the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low transfer pause |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Drive enable for the data output pad |

## Verification
The bench builds the block with its default 512-byte array, 16-byte page and two synchronizer stages. It shortens WC_CYCLES to 1500 so that the busy window spans several frames. This makes it possible to observe, within one run, opcodes being refused while the block is busy, RDY being polled back to 0, and the page-wrap, array-wrap and block-protect boundaries.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
   typedef enum logic [2:0] {
      ST_CMD, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRD, ST_SWR, ST_IGN
   } spim_st_e;

   localparam logic [7:0] OP_WEN   = 8'h06;
   localparam logic [7:0] OP_WDIS  = 8'h04;
   localparam logic [7:0] OP_RSTAT = 8'h05;
   localparam logic [7:0] OP_WSTAT = 8'h01;

   // top2 = the two most significant address bits of the page
   function automatic logic guarded(input logic [1:0] bp, input logic [1:0] top2);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return top2 == 2'b11;
         2'b10:   return top2[1];
         default: return 1'b1;
      endcase
   endfunction
endpackage

// File: rtl/spim_sync.sv
`timescale 1ns/1ps
module spim_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_ff
         logic [W-1:0] r [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) r[k] <= RST_VAL;
            end else begin
               r[0] <= d;
               for (int k = 1; k < STAGES; k++) r[k] <= r[k-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spim_wtimer.sv
`timescale 1ns/1ps
module spim_wtimer #(
   parameter int WC_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(WC_CYCLES + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (start)      cnt <= CW'(WC_CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end
   assign busy = (cnt != '0);

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R9
endmodule

// File: rtl/spim_core.sv
`timescale 1ns/1ps
module spim_core
   import spim_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int PAGE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic si,
   input  logic hold_n,
   input  logic busy,
   output logic so,
   output logic so_oe,
   output logic wc_start
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAGE  = 1 << PAGE_W;

   logic             sck_d, cs_d, paused;
   logic [6:0]       sh;
   logic [2:0]       bitcnt;
   spim_st_e         st;
   logic             wel, a8, is_rd, so_q, out_act, sr_pend, wc_q;
   logic [1:0]       bp, sr_new;
   logic [ADDR_W-1:0] ptr;
   logic [7:0]       obuf;
   logic [7:0]       pbuf [PAGE];
   logic [PAGE-1:0]  vmask;
   logic [7:0]       mem [DEPTH];

   logic act, rise, fall, byte_done, cs_rise, do_wr, do_sr;
   logic [7:0] byte_in, status;
   logic [8:0] full_a;

   assign act       = !cs_n && !paused;
   assign rise      = act && sck && !sck_d;
   assign fall      = act && !sck && sck_d;
   assign byte_in   = {sh, si};
   assign byte_done = rise && (bitcnt == 3'd7);
   assign cs_rise   = cs_n && !cs_d;
   assign full_a    = {a8, byte_in};
   assign status    = {4'hF, bp, wel, busy};
   assign do_wr = cs_rise && st == ST_WDAT && bitcnt == '0 && |vmask && wel
                  && !guarded(bp, ptr[ADDR_W-1 -: 2]);
   assign do_sr = cs_rise && st == ST_SWR && bitcnt == '0 && sr_pend && wel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0; cs_d <= 1'b1; paused <= 1'b0;
         sh <= '0; bitcnt <= '0; st <= ST_CMD;
         wel <= 1'b0; a8 <= 1'b0; is_rd <= 1'b0; so_q <= 1'b0;
         out_act <= 1'b0; sr_pend <= 1'b0; wc_q <= 1'b0;
         bp <= '0; sr_new <= '0; ptr <= '0; obuf <= '0; vmask <= '0;
         for (int i = 0; i < PAGE; i++)  pbuf[i] <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i]  <= '0;
      end else begin
         sck_d <= sck;
         cs_d  <= cs_n;
         wc_q  <= do_wr || do_sr;
         if (cs_n)      paused <= 1'b0;
         else if (!sck) paused <= !hold_n;

         if (do_wr) begin
            for (int i = 0; i < PAGE; i++)
               if (vmask[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
            wel <= 1'b0;
         end
         if (do_sr) begin
            bp  <= sr_new;
            wel <= 1'b0;
         end

         if (cs_n) begin
            st <= ST_CMD; bitcnt <= '0; out_act <= 1'b0;
            sr_pend <= 1'b0; vmask <= '0;
         end else if (rise) begin
            sh     <= byte_in[6:0];
            bitcnt <= bitcnt + 1'b1;
            if (byte_done) begin
               unique case (st)
                  ST_CMD: begin
                     if (busy && byte_in != OP_RSTAT)  st <= ST_IGN;
                     else if (byte_in == OP_WEN)  begin wel <= 1'b1; st <= ST_IGN; end
                     else if (byte_in == OP_WDIS) begin wel <= 1'b0; st <= ST_IGN; end
                     else if (byte_in == OP_RSTAT) begin obuf <= status; st <= ST_SRD; end
                     else if (byte_in == OP_WSTAT) st <= ST_SWR;
                     else if (byte_in[7:4] == 4'h0 && byte_in[2:1] == 2'b01) begin
                        a8 <= byte_in[3]; is_rd <= byte_in[0]; st <= ST_ADDR;
                     end else st <= ST_IGN;
                  end
                  ST_ADDR: begin
                     if (is_rd) begin
                        obuf <= mem[full_a[ADDR_W-1:0]];
                        ptr  <= full_a[ADDR_W-1:0] + 1'b1;
                        st   <= ST_RDAT;
                     end else begin
                        ptr <= full_a[ADDR_W-1:0];
                        st  <= ST_WDAT;
                     end
                  end
                  ST_RDAT: begin
                     obuf <= mem[ptr];
                     ptr  <= ptr + 1'b1;
                  end
                  ST_SRD: obuf <= status;
                  ST_WDAT: begin
                     pbuf[ptr[PAGE_W-1:0]]  <= byte_in;
                     vmask[ptr[PAGE_W-1:0]] <= 1'b1;
                     ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                  end
                  ST_SWR: if (!sr_pend) begin sr_new <= byte_in[3:2]; sr_pend <= 1'b1; end
                  default: ;
               endcase
            end
         end else if (fall && (st == ST_RDAT || st == ST_SRD)) begin
            so_q    <= obuf[7];
            obuf    <= {obuf[6:0], 1'b0};
            out_act <= 1'b1;
         end
      end
   end

   assign so       = so_q;
   assign so_oe    = out_act && !cs_n && !paused;
   assign wc_start = wc_q;

   AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(so_q)); // R1
   AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !out_act); // R2
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && !cs_n) |=> $stable(bitcnt)); // R12
   AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(st inside {ST_ADDR, ST_RDAT, ST_WDAT, ST_SWR})); // R10
   AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      wc_q |-> !wel); // R9
endmodule

// File: rtl/spi_mem_target.sv
`timescale 1ns/1ps
module spi_mem_target #(
   parameter int ADDR_W      = 9,
   parameter int PAGE_W      = 4,
   parameter int WC_CYCLES   = 1000000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_si,
   input  logic spi_hold_n,
   output logic spi_so,
   output logic spi_so_oe
);
   generate
      if (ADDR_W > 9 || ADDR_W < PAGE_W + 2) begin : g_bad_addr
         $error("spi_mem_target: ADDR_W must be in PAGE_W+2 .. 9");
      end
      if (WC_CYCLES < 1) begin : g_bad_wc
         $error("spi_mem_target: WC_CYCLES must be at least 1");
      end
   endgenerate

   logic [3:0] raw, syn;
   logic busy, wc_start;

   assign raw = {spi_sck, spi_cs_n, spi_si, spi_hold_n};

   spim_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

   spim_wtimer #(.WC_CYCLES(WC_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(wc_start), .busy(busy));

   spim_core #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .sck(syn[3]), .cs_n(syn[2]), .si(syn[1]), .hold_n(syn[0]),
      .busy(busy), .so(spi_so), .so_oe(spi_so_oe), .wc_start(wc_start));
endmodule

// File: tb/spi_mem_target_tb.sv
`timescale 1ns/1ps
module spi_mem_target_tb_top;
   localparam int HALF = 8;
   localparam int WC   = 1500;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, sck, cs_n, si, hold_n;
   logic so, so_oe;
   int n_chk = 0, n_fail = 0, cs_hi_cnt = 0;
   bit cpol = 0, oe_seen = 0, done = 0;

   logic [7:0] ref_mem [512];
   bit ref_wel = 0;
   logic [1:0] ref_bp = 2'b00;

   spi_mem_target #(.ADDR_W(9), .PAGE_W(4), .WC_CYCLES(WC), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // per-clock reference: output must be released whenever select is high
   always @(negedge clk) begin
      if (so_oe) oe_seen = 1;
      if (rst_n && cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
      if (cs_hi_cnt >= 4 && !done) check("R2", so_oe, 0);
   end

   task automatic frame_start();
      sck = cpol; tick(HALF); cs_n = 0; tick(HALF);
   endtask

   task automatic frame_end();
      if (!cpol) sck = 0;
      tick(HALF); cs_n = 1; tick(2*HALF);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int hold_bit);
      for (int i = 7; i >= 0; i--) begin
         sck = 0;
         if (i == hold_bit) begin
            tick(HALF); hold_n = 0; tick(HALF);
            check("R12", so_oe, 0);
            sck = 1; tick(HALF); sck = 0; tick(HALF);
            hold_n = 1;
         end
         si = tx[i]; tick(HALF);
         rx[i] = so;
         sck = 1; tick(HALF);
      end
   endtask

   task automatic tx8(input logic [7:0] b);
      logic [7:0] d;
      xfer(b, d, -1);
   endtask

   task automatic bits(input int n);
      for (int i = 0; i < n; i++) begin
         sck = 0; si = 1; tick(HALF); sck = 1; tick(HALF);
      end
   endtask

   task automatic cmd(input logic [7:0] op);
      frame_start(); tx8(op); frame_end();
   endtask

   task automatic rdsr(output logic [7:0] s);
      frame_start(); tx8(8'h05); xfer(8'h00, s, -1); frame_end();
   endtask

   task automatic stat_chk(input string req, input bit rdy);
      logic [7:0] s;
      rdsr(s);
      check(req, s, {4'hF, ref_bp, ref_wel, rdy});
   endtask

   task automatic wait_ready();
      logic [7:0] s;
      for (int k = 0; k < 20; k++) begin
         rdsr(s);
         if (!s[0]) break;
      end
   endtask

   function automatic bit ref_guard(input logic [8:0] a);
      case (ref_bp)
         2'b00: return 0;
         2'b01: return a[8:7] == 2'b11;
         2'b10: return a[8];
         default: return 1;
      endcase
   endfunction

   task automatic wr(input logic [8:0] a, input logic [7:0] q[$]);
      logic [3:0] col;
      frame_start();
      tx8({4'h0, a[8], 3'b010});
      tx8(a[7:0]);
      foreach (q[k]) tx8(q[k]);
      frame_end();
      if (ref_wel && !ref_guard(a)) begin
         col = a[3:0];
         foreach (q[k]) begin
            ref_mem[{a[8:4], col}] = q[k];
            col = col + 1;
         end
         ref_wel = 0;
      end
   endtask

   task automatic wrsr(input logic [7:0] v);
      frame_start(); tx8(8'h01); tx8(v); frame_end();
      if (ref_wel) begin ref_bp = v[3:2]; ref_wel = 0; end
   endtask

   task automatic rd_chk(input logic [8:0] a, input int n, input string req, input int hb);
      logic [7:0] d;
      logic [8:0] p;
      frame_start();
      tx8({4'h0, a[8], 3'b011});
      tx8(a[7:0]);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, d, (k == 1) ? hb : -1);
         p = a + 9'(k);
         check(req, d, ref_mem[p]);
      end
      frame_end();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] s1, s2;
      for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
      rst_n = 0; sck = 0; cs_n = 1; si = 0; hold_n = 1;
      tick(10); rst_n = 1; tick(10);
      check("R2", so_oe, 0);
      stat_chk("R5", 0);

      // R3 enable/disable latch
      cmd(8'h06); ref_wel = 1; stat_chk("R3", 0);
      frame_start(); tx8(8'h05); xfer(8'h00, s1, -1); xfer(8'h00, s2, -1); frame_end();
      check("R5", s1, 8'hF2); check("R5", s2, 8'hF2);
      cmd(8'h04); ref_wel = 0; stat_chk("R3", 0);

      // R9 write without enable is dropped
      wr(9'h010, '{8'hAA}); stat_chk("R9", 0); rd_chk(9'h010, 1, "R9", -1);

      // R9 accepted write, R10 busy gating
      cmd(8'h06); ref_wel = 1;
      wr(9'h000, '{8'hA5, 8'h5A});
      cmd(8'h06);
      frame_start(); tx8(8'h03); tx8(8'h00); oe_seen = 0; tx8(8'h00); tx8(8'h00); frame_end();
      check("R10", oe_seen, 0);
      stat_chk("R10", 1);
      wait_ready(); stat_chk("R9", 0);
      rd_chk(9'h000, 2, "R6", -1);

      // R7 page wrap, R6 array wrap
      cmd(8'h06); ref_wel = 1;
      wr(9'h1FE, '{8'h11, 8'h22, 8'h33});
      wait_ready();
      rd_chk(9'h1FE, 4, "R6", -1);
      rd_chk(9'h1F0, 1, "R7", -1);

      // R4 undefined opcodes
      frame_start(); tx8(8'hFF); tx8(8'h06); frame_end(); stat_chk("R4", 0);
      frame_start(); tx8(8'h13); tx8(8'h00); oe_seen = 0; tx8(8'h00); tx8(8'h00); frame_end();
      check("R4", oe_seen, 0);

      // R7 select rising off a byte boundary
      cmd(8'h06); ref_wel = 1;
      frame_start(); tx8(8'h02); tx8(8'h20); tx8(8'h5A); bits(3); frame_end();
      stat_chk("R7", 0); rd_chk(9'h020, 1, "R7", -1);
      cmd(8'h04); ref_wel = 0;

      // R8 / R11 block protection
      cmd(8'h06); ref_wel = 1; wrsr(8'h08); wait_ready(); stat_chk("R8", 0);
      cmd(8'h06); ref_wel = 1; wr(9'h100, '{8'h77}); stat_chk("R11", 0);
      rd_chk(9'h100, 1, "R11", -1);
      wr(9'h0F0, '{8'h66}); wait_ready(); rd_chk(9'h0F0, 1, "R11", -1);
      cmd(8'h06); ref_wel = 1; wrsr(8'h04); wait_ready();
      cmd(8'h06); ref_wel = 1; wr(9'h180, '{8'h99}); rd_chk(9'h180, 1, "R11", -1);
      wr(9'h17F, '{8'h44}); wait_ready(); rd_chk(9'h17F, 1, "R11", -1);
      cmd(8'h06); ref_wel = 1; wrsr(8'h0C); wait_ready();
      cmd(8'h06); ref_wel = 1; wr(9'h000, '{8'h12}); rd_chk(9'h000, 1, "R11", -1);
      wrsr(8'h00); wait_ready(); stat_chk("R8", 0);

      // R12 pause in the middle of a data byte
      rd_chk(9'h1FE, 3, "R12", 4);

      // R1 mode 3
      cpol = 1;
      stat_chk("R1", 0);
      rd_chk(9'h000, 2, "R1", -1);
      cpol = 0; sck = 0; tick(HALF);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule